// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the single reservation that an atomic read-modify-write sequence needs in a single-core pipeline. A load-linked operation sets a reservation flag and stores the address it used. A store-conditional operation checks that flag. If the flag is still set, the memory write may go ahead and the destination register receives 1. If the flag has been cleared, the write is blocked and the register receives 0.

Anything that breaks the sequence between the two operations drops the reservation: an exception, or a pipeline flush caused by a thread switch. Every store-conditional also consumes the reservation, whether it succeeds or fails. Writes made by other cores are not watched.

The memory stage drives one operation strobe per cycle together with its kind and address. The write-permit output is combinational, so it gates the data-memory write enable in the same cycle. The result value and the reservation state are registered.

Top module: `llsc_link_monitor`

## Requirements
- R1: An accepted load-linked operation (`op_valid`=1, `op_kind`=2'b01, `flush`=0) sets `link_bit` to 1 from the next cycle.
- R2: An accepted load-linked operation captures `op_addr` into `link_addr`, visible from the next cycle. The most recent load-linked address replaces any earlier one.
- R3: A cycle with `flush`=1 clears `link_bit` to 0 from the next cycle.
- R4: A store-conditional (`op_valid`=1, `op_kind`=2'b10, `flush`=0) while `link_bit`=1 drives `store_allow`=1 in that same cycle. From the next cycle, `result_value` reads 1.
- R5: A store-conditional while `link_bit`=0 drives `store_allow`=0 in that cycle. From the next cycle, `result_value` reads 0.
- R6: After any store-conditional executes, `link_bit` is 0 from the next cycle, whether the store succeeded or failed.
- R7: Reset (synchronous, active high) leaves `link_bit`=0, `link_addr`=0 and `result_value`=0.
- R8: When a load-linked operation and `flush` arrive in the same cycle, the flush wins and `link_bit` is 0 afterwards.
- R9: A store-conditional presented together with `flush`=1 is squashed: `store_allow`=0 and `result_value` keeps its previous value.
- R10: Other operations leave `link_bit` and `link_addr` unchanged. These are kind 2'b00 or 2'b11, or any kind presented with `op_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 2 | 01 load-linked, 10 store-conditional, 00/11 other |
| op_addr | input | ADDR_W | Effective address of the operation |
| flush | input | 1 | Exception or thread-switch flush |
| store_allow | output | 1 | Combinational permit for the conditional memory write |
| result_value | output | DATA_W | 1 or 0 from the last executed store-conditional |
| link_bit | output | 1 | Current reservation flag |
| link_addr | output | ADDR_W | Address saved by the last accepted load-linked |

## Verification
A reservation flag stuck at 1 shows up as `store_allow` asserted for a store-conditional that follows a flush or an earlier store-conditional. It also shows up as a 1 in `result_value` one cycle later. A flag that never sets shows up as a failed store right after a clean load-linked. Because the permit is combinational, a wrong flag is visible in the same cycle the store is presented. A lost priority between flush and load-linked shows up as `link_bit` reading 1 in the cycle after the collision.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN = 2'b00,
    KIND_LL    = 2'b01,
    KIND_SC    = 2'b10,
    KIND_RSVD  = 2'b11
  } op_kind_e;
endpackage

// File: rtl/llsc_link_state.sv
module llsc_link_state #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ll_fire,
  input  logic              sc_fire,
  input  logic              flush,
  input  logic [ADDR_W-1:0] addr,
  output logic              link_q,
  output logic [ADDR_W-1:0] addr_q
);
  // flush beats load-linked; store-conditional consumes the reservation
  always_ff @(posedge clk) begin
    if (rst) begin
      link_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (flush || sc_fire)
        link_q <= 1'b0;
      else if (ll_fire)
        link_q <= 1'b1;
      if (ll_fire && !flush)
        addr_q <= addr;
    end
  end

  AST_LL_SETS_LINK: assert property (@(posedge clk) disable iff (rst)
    (ll_fire && !flush) |=> link_q); // R1
  AST_LL_SAVES_ADDR: assert property (@(posedge clk) disable iff (rst)
    (ll_fire && !flush) |=> (addr_q == $past(addr))); // R2
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !link_q); // R3
  AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (rst)
    sc_fire |=> !link_q); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ll_fire && !sc_fire && !flush) |=> ($stable(link_q) && $stable(addr_q))); // R10
endmodule

// File: rtl/llsc_sc_resolve.sv
module llsc_sc_resolve #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sc_fire,
  input  logic              link_q,
  output logic              permit,
  output logic [DATA_W-1:0] result_q
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  assign permit = sc_fire && link_q;

  always_ff @(posedge clk) begin
    if (rst)
      result_q <= '0;
    else if (sc_fire)
      result_q <= permit ? ONE : '0;
  end

  AST_PERMIT_NEEDS_LINK: assert property (@(posedge clk) disable iff (rst)
    permit |-> link_q); // R5
  AST_RESULT_MATCHES: assert property (@(posedge clk) disable iff (rst)
    sc_fire |=> (result_q == ($past(link_q) ? ONE : '0))); // R4
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !sc_fire |=> $stable(result_q)); // R9
endmodule

// File: rtl/llsc_link_monitor.sv
module llsc_link_monitor
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              flush,
  output logic              store_allow,
  output logic [DATA_W-1:0] result_value,
  output logic              link_bit,
  output logic [ADDR_W-1:0] link_addr
);
  logic ll_fire;
  logic sc_fire;

  assign ll_fire = op_valid && (op_kind_e'(op_kind) == KIND_LL);
  // a flushed store-conditional is squashed entirely
  assign sc_fire = op_valid && (op_kind_e'(op_kind) == KIND_SC) && !flush;

  llsc_link_state #(.ADDR_W(ADDR_W)) u_state (
    .clk(clk), .rst(rst), .ll_fire(ll_fire), .sc_fire(sc_fire),
    .flush(flush), .addr(op_addr), .link_q(link_bit), .addr_q(link_addr)
  );

  llsc_sc_resolve #(.DATA_W(DATA_W)) u_resolve (
    .clk(clk), .rst(rst), .sc_fire(sc_fire), .link_q(link_bit),
    .permit(store_allow), .result_q(result_value)
  );

  AST_FLUSH_BLOCKS_STORE: assert property (@(posedge clk) disable iff (rst)
    flush |-> !store_allow); // R9
  AST_COLLIDE_FLUSH_WINS: assert property (@(posedge clk) disable iff (rst)
    (ll_fire && flush) |=> !link_bit); // R8
endmodule

// File: tb/llsc_link_monitor_tb_top.sv
module llsc_link_monitor_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  logic op_valid;
  logic [1:0] op_kind;
  logic [AW-1:0] op_addr;
  logic flush;
  logic store_allow;
  logic [DW-1:0] result_value;
  logic link_bit;
  logic [AW-1:0] link_addr;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  llsc_link_monitor #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .flush(flush), .store_allow(store_allow),
    .result_value(result_value), .link_bit(link_bit), .link_addr(link_addr)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, return just before the next posedge
  task automatic drive(logic v, logic [1:0] k, logic [AW-1:0] a, logic f);
    @(negedge clk);
    op_valid = v; op_kind = k; op_addr = a; flush = f;
    #1;
  endtask

  // let the edge happen, then idle
  task automatic settle();
    @(posedge clk); #1;
    op_valid = 1'b0; op_kind = 2'b00; flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7 link_bit", link_bit, 0);
    chk("R7 link_addr", link_addr, 0);
    chk("R7 result", result_value, 0);
    drive(1, 2'b10, 32'h0, 0);
    chk("R5 allow after reset", store_allow, 0);
    settle();
    chk("R5 result after reset", result_value, 0);
  endtask

  task automatic t_ll_sc_ok();
    drive(1, 2'b01, 32'h0000_1040, 0); settle();
    chk("R1 link set", link_bit, 1);
    chk("R2 addr", link_addr, 32'h0000_1040);
    drive(1, 2'b10, 32'h0000_1040, 0);
    chk("R4 allow", store_allow, 1);
    settle();
    chk("R4 result one", result_value, 1);
    chk("R6 cleared after success", link_bit, 0);
  endtask

  task automatic t_sc_fail();
    drive(1, 2'b10, 32'h0000_1040, 0);
    chk("R5 allow blocked", store_allow, 0);
    settle();
    chk("R5 result zero", result_value, 0);
    chk("R6 cleared after fail", link_bit, 0);
  endtask

  task automatic t_flush_between();
    drive(1, 2'b01, 32'h0000_2000, 0); settle();
    drive(0, 2'b00, 32'h0, 1); settle();
    chk("R3 flush clears", link_bit, 0);
    drive(1, 2'b10, 32'h0000_2000, 0);
    chk("R3 sc after flush blocked", store_allow, 0);
    settle();
    chk("R3 sc after flush result", result_value, 0);
  endtask

  task automatic t_collide();
    drive(1, 2'b01, 32'h0000_3000, 1); settle();
    chk("R8 flush beats ll", link_bit, 0);
  endtask

  task automatic t_flushed_sc();
    drive(1, 2'b01, 32'h0000_4000, 0); settle();
    drive(1, 2'b10, 32'h0000_4000, 0); settle();
    chk("R4 setup result", result_value, 1);
    drive(1, 2'b01, 32'h0000_4004, 0); settle();
    drive(1, 2'b10, 32'h0000_4004, 1);
    chk("R9 squashed allow", store_allow, 0);
    settle();
    chk("R9 result kept", result_value, 1);
    chk("R3 link after flushed sc", link_bit, 0);
  endtask

  task automatic t_other_ops();
    drive(1, 2'b01, 32'h0000_5000, 0); settle();
    drive(1, 2'b00, 32'h0000_6000, 0); settle();
    drive(1, 2'b11, 32'h0000_6004, 0); settle();
    drive(0, 2'b01, 32'h0000_6008, 0); settle();
    drive(0, 2'b10, 32'h0000_600c, 0);
    chk("R10 invalid sc no allow", store_allow, 0);
    settle();
    chk("R10 link kept", link_bit, 1);
    chk("R10 addr kept", link_addr, 32'h0000_5000);
    drive(1, 2'b01, 32'h0000_7abc, 0); settle();
    chk("R2 addr replaced", link_addr, 32'h0000_7abc);
    drive(1, 2'b10, 32'h0000_7abc, 0);
    chk("R4 allow after relink", store_allow, 1);
    settle();
  endtask

  initial begin
    rst = 1'b1; op_valid = 0; op_kind = 0; op_addr = 0; flush = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_ll_sc_ok();
    t_sc_fail();
    t_flush_between();
    t_collide();
    t_flushed_sc();
    t_other_ops();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule